// File: doc/BRIEF.md
# Serial ADC Power-Down Sequencer

This block is the device-side control logic of a serial sampling converter. It watches a serial clock and an active-low chip select, counts serial clock edges inside each frame, raises a one-cycle strobe when the conversion of the frame ends, and shifts the result out most significant bit first. A power-down request input, sampled only when chip select is released, tells the block to power down as soon as the next conversion has finished. The block then reports a power state: active, dynamic power-down (data may still be clocked out), static power-down (the serial clock has stopped), or waking.

All logic runs on one free-running reference clock `clk`. Serial clock and chip select are treated as slow inputs whose edges are found by comparison with their value one reference cycle earlier. The analog core is replaced by the `conv_data` input, which is captured when the conversion ends. The frame type (short or long) is taken from the number of serial clock falling edges seen while chip select was low. After a wake-up, a fixed number of reference cycles must pass before a new frame may start. A frame that starts earlier is flagged as invalid.

Top module: `adc_pd_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `pwr_state` is 0 (active), `frame_long` is 0, and `conv_done`, `sdo` and `sample_invalid` are 0.
- R2: `conv_done` is high for exactly one `clk` cycle, in the cycle after the block sees the Nth serial clock rising edge of a frame. N is 14, 11 or 9 for a resolution of 12, 10 or 8 bits. The pulse occurs only if the state was active (0) when that edge was seen. No pulse occurs in a frame that runs while the block is powered down.
- R3: `pd_en` is read only in the cycle in which chip select is seen rising. Changes of `pd_en` at any other time have no effect on `pwr_state`.
- R4: If `pd_en` was 1 at the last chip-select rising edge, the state changes from active (0) to dynamic power-down (1) in the same cycle as the `conv_done` pulse.
- R5: When a conversion ends, `sdo` shows the result MSB. On each later serial clock falling edge while chip select is low, `sdo` moves to the next lower bit. After the LSB it shows 0. `sdo` is 0 from chip select falling until the conversion ends.
- R6: On each chip-select rising edge, `frame_long` is updated. It becomes 1 if more than 29 serial clock falling edges were seen while chip select was low in that frame, and 0 otherwise.
- R7: In dynamic power-down (1), after `IDLE_CYCLES` consecutive `clk` cycles with no serial clock edge, the state becomes static power-down (2).
- R8: In power-down (1 or 2), a chip-select rising edge with `pd_en` low moves the state to waking (3). A chip-select rising edge with `pd_en` high leaves the block powered down.
- R9: In power-down, a serial clock rising edge seen while chip select is high moves the state to waking (3), but only when `frame_long` is 1.
- R10: Waking (3) lasts exactly `WAKE_CYCLES` `clk` cycles and is always followed by active (0).
- R11: At each chip-select falling edge, `sample_invalid` becomes 1 if the state was waking (3), and 0 otherwise. It holds that value until the next chip-select falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| pd_en | input | 1 | Power-down request, read at chip-select rising edge |
| conv_data | input | RES_BITS | Result from the converter core, captured at conversion end |
| sdo | output | 1 | Serial data out, MSB first |
| conv_done | output | 1 | One-cycle strobe at conversion end |
| pwr_state | output | 2 | 0 active, 1 dynamic power-down, 2 static power-down, 3 waking |
| frame_long | output | 1 | 1 if the last completed frame was a long frame |
| sample_invalid | output | 1 | Current frame started before the wake interval had elapsed |

## Verification
If the serial clock edge count is wrong, the next frame shows it. `conv_done` appears one rising edge early or late, and the MSB on `sdo` moves with it. A falling-edge count off by one shows at the next chip-select rise, but only in a frame of 29 or 30 edges, where `frame_long` comes out wrong. If the power-down request is latched at the wrong time, the state does not leave active in the cycle of the `conv_done` pulse. A wrong idle or wake counter moves the entry into state 2 or the return to 0 by that many cycles. All of these are seen at the ports in the cycle in which they occur.

// File: rtl/adc_pd_pkg.sv
package adc_pd_pkg;

   typedef enum logic [1:0] {
      PWR_ACTIVE = 2'd0,
      PWR_DYN    = 2'd1,
      PWR_STATIC = 2'd2,
      PWR_WAKE   = 2'd3
   } pwr_state_t;

   // serial clock rising edge on which a conversion completes
   function automatic int conv_edge(input int res);
      if (res == 12) return 14;
      else if (res == 10) return 11;
      else return 9;
   endfunction

endpackage

// File: rtl/adc_pd_edge.sv
module adc_pd_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic din_q;

   always_ff @(posedge clk) begin
      if (rst) din_q <= RST_VAL;
      else     din_q <= din;
   end

   assign rise = din & ~din_q;
   assign fall = ~din & din_q;
endmodule

// File: rtl/adc_pd_frame.sv
module adc_pd_frame #(
   parameter int CONV_EDGE  = 14,
   parameter int FALL_LIMIT = 29
) (
   input  logic clk,
   input  logic rst,
   input  logic cs_low,
   input  logic cs_fall,
   input  logic cs_rise,
   input  logic sclk_rise,
   input  logic sclk_fall,
   input  logic core_active,
   output logic conv_hit,
   output logic conv_done,
   output logic frame_long
);
   localparam int RW = $clog2(CONV_EDGE + 1);
   localparam int FW = $clog2(FALL_LIMIT + 2);
   localparam logic [RW-1:0] R_LAST = RW'(CONV_EDGE - 1);
   localparam logic [RW-1:0] R_SAT  = RW'(CONV_EDGE);
   localparam logic [FW-1:0] F_LIM  = FW'(FALL_LIMIT);

   logic [RW-1:0] rcnt_q;
   logic [FW-1:0] fcnt_q;
   logic          in_frame;

   assign in_frame = cs_low & ~cs_fall;
   assign conv_hit = in_frame & sclk_rise & (rcnt_q == R_LAST) & core_active;

   always_ff @(posedge clk) begin
      if (rst) begin
         rcnt_q     <= '0;
         fcnt_q     <= '0;
         conv_done  <= 1'b0;
         frame_long <= 1'b0;
      end else begin
         conv_done <= conv_hit;
         if (cs_fall) begin
            rcnt_q <= '0;
            fcnt_q <= '0;
         end else if (in_frame) begin
            if (sclk_rise && rcnt_q != R_SAT) rcnt_q <= rcnt_q + 1'b1;
            if (sclk_fall && fcnt_q <= F_LIM) fcnt_q <= fcnt_q + 1'b1;
         end
         if (cs_rise) frame_long <= (fcnt_q > F_LIM);
      end
   end

   AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      conv_done |=> !conv_done); // R2
endmodule

// File: rtl/adc_pd_power.sv
module adc_pd_power
   import adc_pd_pkg::*;
#(
   parameter int IDLE_CYCLES = 16,
   parameter int WAKE_CYCLES = 12
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cs_n,
   input  logic       cs_rise,
   input  logic       cs_fall,
   input  logic       sclk_rise,
   input  logic       sclk_fall,
   input  logic       pd_en,
   input  logic       conv_hit,
   input  logic       frame_long,
   output pwr_state_t state_q,
   output logic       active,
   output logic       sample_invalid
);
   localparam int IW = $clog2(IDLE_CYCLES + 1);
   localparam int WW = $clog2(WAKE_CYCLES + 1);
   localparam logic [IW-1:0] I_LAST = IW'(IDLE_CYCLES - 1);
   localparam logic [WW-1:0] W_LAST = WW'(WAKE_CYCLES - 1);

   logic [IW-1:0] idle_q;
   logic [WW-1:0] wake_q;
   logic          armed_q;
   logic          wake_req;
   logic          is_down;

   assign active   = (state_q == PWR_ACTIVE);
   assign is_down  = (state_q == PWR_DYN) || (state_q == PWR_STATIC);
   assign wake_req = (cs_rise & ~pd_en) | (sclk_rise & cs_n & frame_long);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q        <= PWR_ACTIVE;
         idle_q         <= '0;
         wake_q         <= '0;
         armed_q        <= 1'b0;
         sample_invalid <= 1'b0;
      end else begin
         if (cs_rise) armed_q <= pd_en;
         if (cs_fall) sample_invalid <= (state_q == PWR_WAKE);
         unique case (state_q)
            PWR_ACTIVE: begin
               if (conv_hit && armed_q) begin
                  state_q <= PWR_DYN;
                  idle_q  <= '0;
               end
            end
            PWR_DYN, PWR_STATIC: begin
               if (wake_req) begin
                  state_q <= PWR_WAKE;
                  wake_q  <= '0;
               end else if (state_q == PWR_DYN) begin
                  if (sclk_rise || sclk_fall) idle_q <= '0;
                  else if (idle_q == I_LAST)  state_q <= PWR_STATIC;
                  else                        idle_q <= idle_q + 1'b1;
               end
            end
            PWR_WAKE: begin
               if (wake_q == W_LAST) state_q <= PWR_ACTIVE;
               else                  wake_q  <= wake_q + 1'b1;
            end
            default: state_q <= PWR_ACTIVE;
         endcase
      end
   end

   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
      ($past(state_q) == PWR_WAKE && state_q != PWR_WAKE) |-> state_q == PWR_ACTIVE); // R10
   AST_STATIC_FROM_DYN: assert property (@(posedge clk) disable iff (rst)
      (state_q == PWR_STATIC && $past(state_q) != PWR_STATIC) |-> $past(state_q) == PWR_DYN); // R7
   AST_STAY_DOWN: assert property (@(posedge clk) disable iff (rst)
      (cs_rise && pd_en && !sclk_rise && is_down) |=> (state_q == PWR_DYN || state_q == PWR_STATIC)); // R8
endmodule

// File: rtl/adc_pd_shift.sv
module adc_pd_shift #(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cs_low,
   input  logic                cs_fall,
   input  logic                sclk_fall,
   input  logic                conv_hit,
   input  logic [RES_BITS-1:0] conv_data,
   output logic                sdo
);
   localparam int LW = $clog2(RES_BITS + 1);

   logic [RES_BITS-1:0] sh_q;
   logic [LW-1:0]       left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         left_q <= '0;
         sdo    <= 1'b0;
      end else if (cs_fall) begin
         left_q <= '0;
         sdo    <= 1'b0;
      end else if (conv_hit) begin
         sdo    <= conv_data[RES_BITS-1];
         sh_q   <= conv_data << 1;
         left_q <= LW'(RES_BITS - 1);
      end else if (sclk_fall && cs_low) begin
         if (left_q != '0) begin
            sdo    <= sh_q[RES_BITS-1];
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
         end else begin
            sdo <= 1'b0;
         end
      end
   end

   AST_SDO_CLEAR: assert property (@(posedge clk) disable iff (rst)
      cs_fall |=> !sdo); // R5
endmodule

// File: rtl/adc_pd_sequencer.sv
module adc_pd_sequencer
   import adc_pd_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int FALL_LIMIT  = 29,
   parameter int IDLE_CYCLES = 16,
   parameter int WAKE_CYCLES = 12
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                pd_en,
   input  logic [RES_BITS-1:0] conv_data,
   output logic                sdo,
   output logic                conv_done,
   output logic [1:0]          pwr_state,
   output logic                frame_long,
   output logic                sample_invalid
);
   localparam int CONV_EDGE = conv_edge(RES_BITS);

   generate
      if (RES_BITS != 12 && RES_BITS != 10 && RES_BITS != 8) begin : g_bad_res
         $error("RES_BITS must be 8, 10 or 12");
      end
      if (IDLE_CYCLES < 1 || WAKE_CYCLES < 1) begin : g_bad_cnt
         $error("IDLE_CYCLES and WAKE_CYCLES must be at least 1");
      end
      if (FALL_LIMIT < CONV_EDGE) begin : g_bad_lim
         $error("FALL_LIMIT must not be below the conversion edge");
      end
   endgenerate

   logic       sclk_rise, sclk_fall, cs_rise, cs_fall;
   logic       conv_hit, core_active;
   pwr_state_t state;

   adc_pd_edge #(.RST_VAL(1'b0)) i_sclk_edge (
      .clk(clk), .rst(rst), .din(sclk), .rise(sclk_rise), .fall(sclk_fall));

   adc_pd_edge #(.RST_VAL(1'b1)) i_cs_edge (
      .clk(clk), .rst(rst), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

   adc_pd_frame #(.CONV_EDGE(CONV_EDGE), .FALL_LIMIT(FALL_LIMIT)) i_frame (
      .clk(clk), .rst(rst), .cs_low(~cs_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .core_active(core_active),
      .conv_hit(conv_hit), .conv_done(conv_done), .frame_long(frame_long));

   adc_pd_power #(.IDLE_CYCLES(IDLE_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) i_power (
      .clk(clk), .rst(rst), .cs_n(cs_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .pd_en(pd_en),
      .conv_hit(conv_hit), .frame_long(frame_long), .state_q(state),
      .active(core_active), .sample_invalid(sample_invalid));

   adc_pd_shift #(.RES_BITS(RES_BITS)) i_shift (
      .clk(clk), .rst(rst), .cs_low(~cs_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
      .conv_hit(conv_hit), .conv_data(conv_data), .sdo(sdo));

   assign pwr_state = state;

   AST_CONV_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      conv_done |-> $past(pwr_state) == 2'd0); // R2
   AST_DYN_WITH_CONV: assert property (@(posedge clk) disable iff (rst)
      (pwr_state == 2'd1 && $past(pwr_state) == 2'd0) |-> conv_done); // R4
endmodule

// File: tb/test_adc_pd_sequencer.sv
module test_adc_pd_sequencer;
   localparam int RES  = 12;
   localparam int CE   = 14;
   localparam int LIM  = 29;
   localparam int IDLE = 16;
   localparam int WAKE = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic pd_en = 1'b0;
   logic [RES-1:0] conv_data = '0;
   logic sdo, conv_done, frame_long, sample_invalid;
   logic [1:0] pwr_state;

   int checks = 0;
   int errors = 0;
   int conv_seen = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   adc_pd_sequencer #(.RES_BITS(RES), .FALL_LIMIT(LIM), .IDLE_CYCLES(IDLE),
                      .WAKE_CYCLES(WAKE)) i_adc_pd_sequencer (
      .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .pd_en(pd_en),
      .conv_data(conv_data), .sdo(sdo), .conv_done(conv_done),
      .pwr_state(pwr_state), .frame_long(frame_long), .sample_invalid(sample_invalid));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model, evaluated on every rising clock edge
   int  m_state, m_rc, m_fc, m_idle, m_wake;
   bit  m_long, m_inv, m_sdo, m_conv, m_arm, p_s, p_c;
   bit  bitq[$];

   always @(posedge clk) begin
      bit sr, sf, cr, cf, hit, long_old;
      int st_old;
      if (rst) begin
         m_state = 0; m_rc = 0; m_fc = 0; m_idle = 0; m_wake = 0;
         m_long = 0; m_inv = 0; m_sdo = 0; m_conv = 0; m_arm = 0;
         p_s = 0; p_c = 1; bitq.delete();
      end else begin
         sr = sclk && !p_s; sf = !sclk && p_s;
         cr = cs_n && !p_c; cf = !cs_n && p_c;
         st_old = m_state; long_old = m_long; hit = 0;
         if (cf) begin m_rc = 0; m_fc = 0; end
         else if (!cs_n) begin
            if (sr && m_rc < CE) begin
               m_rc++;
               if (m_rc == CE && st_old == 0) hit = 1;
            end
            if (sf && m_fc <= LIM) m_fc++;
         end
         if (cr) m_long = (m_fc > LIM);
         if (cf) begin bitq.delete(); m_sdo = 0; end
         else if (hit) begin
            bitq.delete();
            for (int b = RES - 1; b >= 0; b--) bitq.push_back(conv_data[b]);
            m_sdo = bitq.pop_front();
         end else if (sf && !cs_n) m_sdo = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
         if (st_old == 0) begin
            if (hit && m_arm) begin m_state = 1; m_idle = 0; end
         end else if (st_old == 1 || st_old == 2) begin
            if ((cr && !pd_en) || (sr && cs_n && long_old)) begin m_state = 3; m_wake = 0; end
            else if (st_old == 1) begin
               if (sr || sf) m_idle = 0;
               else if (m_idle == IDLE - 1) m_state = 2;
               else m_idle++;
            end
         end else begin
            if (m_wake == WAKE - 1) m_state = 0; else m_wake++;
         end
         if (cr) m_arm = pd_en;
         if (cf) m_inv = (st_old == 3);
         m_conv = hit;
         p_s = sclk; p_c = cs_n;
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         check("R4 R7 R8 R9 R10 pwr_state", pwr_state, m_state);
         check("R2 conv_done", conv_done, m_conv);
         check("R5 sdo", sdo, m_sdo);
         check("R6 frame_long", frame_long, m_long);
         check("R11 sample_invalid", sample_invalid, m_inv);
         if (conv_done) conv_seen++;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input int n, input logic [RES-1:0] d, input bit pd_mid, input bit pd_end);
      conv_data = d;
      @(negedge clk); cs_n = 1'b0;
      wait_n(2);
      pd_en = pd_mid;
      for (int k = 0; k < n; k++) begin
         sclk = 1'b1; wait_n(2);
         sclk = 1'b0; wait_n(2);
      end
      pd_en = pd_end;
      @(negedge clk); cs_n = 1'b1;
      wait_n(3);
   endtask

   task automatic pulse_sclk();
      sclk = 1'b1; wait_n(2);
      sclk = 1'b0; wait_n(3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int c0;
      wait_n(3);
      check("R1 pwr_state in reset", pwr_state, 0);
      check("R1 sdo in reset", sdo, 0);
      check("R1 conv_done in reset", conv_done, 0);
      @(negedge clk); rst = 1'b0;
      wait_n(1);
      check("R1 frame_long", frame_long, 0);
      check("R1 sample_invalid", sample_invalid, 0);

      c0 = conv_seen;
      frame(16, 12'hA5C, 1'b0, 1'b0);
      check("R2 one pulse per frame", conv_seen - c0, 1);

      // R3: pd_en raised inside the frame but low at chip-select rise
      frame(16, 12'h3F1, 1'b1, 1'b0);
      frame(16, 12'h801, 1'b1, 1'b0);
      check("R3 mid-frame pd_en ignored", pwr_state, 0);

      frame(16, 12'h555, 1'b0, 1'b1);
      c0 = conv_seen;
      frame(16, 12'hC3A, 1'b0, 1'b1);
      check("R2 conversion in armed frame", conv_seen - c0, 1);
      check("R4 dynamic power-down", pwr_state, 1);
      pulse_sclk();
      check("R9 short frame, no wake on sclk", pwr_state, 1);
      wait_n(IDLE + 4);
      check("R7 static after idle", pwr_state, 2);

      c0 = conv_seen;
      frame(16, 12'hFFF, 1'b0, 1'b1);
      check("R2 no conversion while down", conv_seen - c0, 0);
      check("R8 stays down with pd_en high", pwr_state == 1 || pwr_state == 2, 1);

      frame(16, 12'h0F0, 1'b0, 1'b0);
      check("R8 wake on cs rise, pd_en low", pwr_state, 3);
      frame(16, 12'h123, 1'b0, 1'b0);
      check("R11 early sample flagged", sample_invalid, 1);
      check("R10 active after wake", pwr_state, 0);
      wait_n(WAKE + 4);
      frame(16, 12'h456, 1'b0, 1'b1);
      check("R11 flag cleared", sample_invalid, 0);

      frame(32, 12'hB2D, 1'b0, 1'b1);
      check("R6 long frame", frame_long, 1);
      check("R4 down after long frame", pwr_state, 1);
      pulse_sclk();
      check("R9 wake on sclk with cs high", pwr_state, 3);
      wait_n(WAKE + 4);
      check("R10 back to active", pwr_state, 0);

      frame(29, 12'h6E7, 1'b0, 1'b0);
      check("R6 29 falling edges is short", frame_long, 0);
      frame(30, 12'h9A9, 1'b0, 1'b0);
      check("R6 30 falling edges is long", frame_long, 1);
      frame(16, 12'h1E1, 1'b0, 1'b0);
      check("R6 back to short", frame_long, 0);
      wait_n(5);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule